// File: doc/BRIEF.md
# Synchronous Offset Gross-Error Monitor

This block runs beside the data path of a parallel SCSI controller during synchronous transfers. It counts the data strobes that have been sent but not yet answered: REQ pulses raise the count and ACK pulses lower it. In target mode the device sends REQ and receives ACK. In initiator mode it is the other way round. While it counts, the block watches for misuse of the offset and the data FIFO. Every misuse it finds is gathered into one gross-error flag.

The flags sit in a status byte. The gross-error flag is at bit 3, reselected at bit 4, selected at bit 5 and function-complete at bit 6. Bits 0, 1, 2 and 7 always read zero. All flags are sticky and clear together when the controller reads the byte. The interrupt line is high whenever any flag is set. The counter is controlled by a two-state machine. ST_IDLE means no offset is outstanding. ST_OPEN means at least one REQ is still waiting for its ACK. The transitions are:
- ST_IDLE to ST_OPEN on an accepted REQ.
- ST_OPEN to ST_IDLE on an ACK that brings the count from one to zero.
- ST_OPEN to ST_IDLE on any bus phase change.

Top module: `sync_ofs_monitor`

## Requirements
- R1: A REQ pulse alone raises offset_cnt by one. An ACK pulse alone lowers it by one. REQ and ACK in the same cycle leave it unchanged. The count appears on offset_cnt one clock after the strobe.
- R2: A phase_chg pulse sets offset_cnt to zero on the next clock, in either mode.
- R3: A REQ alone while offset_cnt is already greater than or equal to max_offset sets stat_byte bit 3. offset_cnt then holds its value.
- R4: Data overflow sets stat_byte bit 3. This happens when fifo_wr is high while fifo_full is high. It also happens when a REQ alone arrives while offset_cnt is already equal to FIFO_DEPTH; offset_cnt then holds its value. fifo_wr without fifo_full sets nothing.
- R5: fifo_rd while fifo_empty is high sets stat_byte bit 3. fifo_rd without fifo_empty sets nothing.
- R6: In target mode (is_target=1), an ACK alone while offset_cnt is zero sets stat_byte bit 3. In initiator mode the same event sets nothing. In both modes offset_cnt stays zero.
- R7: In initiator mode, phase_chg while offset_cnt is nonzero sets stat_byte bit 3. In target mode, or with offset_cnt at zero, phase_chg sets nothing.
- R8: sel_evt sets stat_byte bit 5 only when sel_en and id_match are both high.
- R9: resel_evt sets stat_byte bit 4 only when resel_en and id_match are both high.
- R10: arb_done sets stat_byte bit 6.
- R11: Flags are sticky. stat_rd_clr clears all of them on the next clock. An event arriving in the same cycle as stat_rd_clr leaves its own flag set.
- R12: irq is high exactly when any bit of stat_byte is set.
- R13: After reset, stat_byte, irq and offset_cnt are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_target | input | 1 | 1 = target mode, 0 = initiator mode |
| req_pulse | input | 1 | Single-cycle REQ strobe |
| ack_pulse | input | 1 | Single-cycle ACK strobe |
| max_offset | input | OFS_W | Programmed maximum synchronous offset |
| fifo_rd | input | 1 | Data FIFO read request |
| fifo_wr | input | 1 | Data FIFO write request |
| fifo_empty | input | 1 | Data FIFO empty flag |
| fifo_full | input | 1 | Data FIFO full flag |
| phase_chg | input | 1 | Bus phase-change pulse |
| sel_evt | input | 1 | Selection event |
| resel_evt | input | 1 | Reselection event |
| arb_done | input | 1 | Arbitration sequence finished |
| sel_en | input | 1 | Respond-to-selection enable |
| resel_en | input | 1 | Respond-to-reselection enable |
| id_match | input | 1 | Selecting ID equals the device's response ID |
| stat_rd_clr | input | 1 | Read-to-clear strobe for stat_byte |
| stat_byte | output | 8 | Sticky status flags |
| irq | output | 1 | Interrupt, OR of all flags |
| offset_cnt | output | OFS_W | Outstanding synchronous offset |

## Verification
Some properties are checked by assertions on every cycle:
- The state machine agrees with the counter.
- An accepted REQ raises the count by one.
- A phase change empties the counter.
- A target-mode ACK at zero offset raises the gross-error flag.
- A flag stays set until it is cleared.
- A clear with no new event empties the byte.
- A qualified selection sets its flag.

Other behaviour only the bench scenarios can show:
- The negative cases: initiator ACK at zero, target phase change, unmatched IDs, FIFO access without a full or empty flag.
- The 16-REQ FIFO-capacity boundary.
- A clear racing a new event.
- The exact value of the whole status byte.

// File: rtl/sync_ofs_pkg.sv
package sync_ofs_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OPEN = 1'b1
    } ofs_state_t;

    localparam int BIT_GE  = 3;
    localparam int BIT_RSL = 4;
    localparam int BIT_SEL = 5;
    localparam int BIT_CMP = 6;

endpackage

// File: rtl/ofs_tracker.sv
module ofs_tracker
    import sync_ofs_pkg::*;
#(
    parameter int OFS_W      = 5,
    parameter int FIFO_DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_target,
    input  logic             req_pulse,
    input  logic             ack_pulse,
    input  logic             phase_chg,
    input  logic [OFS_W-1:0] max_offset,
    output logic [OFS_W-1:0] cnt,
    output logic             err_ofs_ovf,
    output logic             err_cap_ovf,
    output logic             err_ofs_unf,
    output logic             err_phase
);

    localparam logic [OFS_W-1:0] CAP = OFS_W'(FIFO_DEPTH);
    localparam logic [OFS_W-1:0] ONE = OFS_W'(1);

    ofs_state_t       state_q, state_n;
    logic [OFS_W-1:0] cnt_q, cnt_n;
    logic             inc, dec, accept;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // Next-state and output process
    always_comb begin
        inc         = req_pulse & ~ack_pulse;
        dec         = ack_pulse & ~req_pulse;
        err_ofs_ovf = inc && (cnt_q >= max_offset);
        err_cap_ovf = inc && (cnt_q >= CAP);
        accept      = inc && !err_ofs_ovf && !err_cap_ovf;
        err_ofs_unf = 1'b0;
        err_phase   = 1'b0;
        state_n     = state_q;
        cnt_n       = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                err_ofs_unf = is_target && dec;
                if (!phase_chg && accept) begin
                    state_n = ST_OPEN;
                end
            end
            ST_OPEN: begin
                err_phase = !is_target && phase_chg;
                if (phase_chg || (dec && cnt_q == ONE)) begin
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
        if (phase_chg) begin
            cnt_n = '0;
        end else if (accept) begin
            cnt_n = cnt_q + ONE;
        end else if (dec && cnt_q != '0) begin
            cnt_n = cnt_q - ONE;
        end
    end

    assign cnt = cnt_q;

    AST_STATE_MATCHES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) == (cnt_q == '0)); // R1

    AST_ACCEPTED_REQ_INCREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_pulse && !ack_pulse && !phase_chg && cnt_q < max_offset && cnt_q < CAP)
        |=> cnt_q == $past(cnt_q) + ONE); // R1

    AST_PHASE_EMPTIES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        phase_chg |=> cnt_q == '0); // R2

endmodule

// File: rtl/fifo_misuse_chk.sv
module fifo_misuse_chk (
    input  logic fifo_rd,
    input  logic fifo_wr,
    input  logic fifo_empty,
    input  logic fifo_full,
    output logic err_unf,
    output logic err_ovf
);

    always_comb begin
        err_unf = fifo_rd & fifo_empty;
        err_ovf = fifo_wr & fifo_full;
    end

endmodule

// File: rtl/status_sticky.sv
module status_sticky
    import sync_ofs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_ge,
    input  logic       set_rsl,
    input  logic       set_sel,
    input  logic       set_cmp,
    input  logic       rd_clr,
    output logic [7:0] stat
);

    logic [7:0] set_vec, stat_q;

    always_comb begin
        set_vec          = '0;
        set_vec[BIT_GE]  = set_ge;
        set_vec[BIT_RSL] = set_rsl;
        set_vec[BIT_SEL] = set_sel;
        set_vec[BIT_CMP] = set_cmp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (rd_clr ? 8'h00 : stat_q) | set_vec;
        end
    end

    assign stat = stat_q;

    AST_GE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[BIT_GE] && !rd_clr) |=> stat_q[BIT_GE]); // R11

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !set_ge && !set_rsl && !set_sel && !set_cmp) |=> stat_q == 8'h00); // R11

endmodule

// File: rtl/sync_ofs_monitor.sv
module sync_ofs_monitor
    import sync_ofs_pkg::*;
#(
    parameter int OFS_W      = 5,
    parameter int FIFO_DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_target,
    input  logic             req_pulse,
    input  logic             ack_pulse,
    input  logic [OFS_W-1:0] max_offset,
    input  logic             fifo_rd,
    input  logic             fifo_wr,
    input  logic             fifo_empty,
    input  logic             fifo_full,
    input  logic             phase_chg,
    input  logic             sel_evt,
    input  logic             resel_evt,
    input  logic             arb_done,
    input  logic             sel_en,
    input  logic             resel_en,
    input  logic             id_match,
    input  logic             stat_rd_clr,
    output logic [7:0]       stat_byte,
    output logic             irq,
    output logic [OFS_W-1:0] offset_cnt
);

    logic e_ofs_ovf, e_cap_ovf, e_ofs_unf, e_phase;
    logic e_fifo_unf, e_fifo_ovf;
    logic gross, sel_ok, rsl_ok;

    ofs_tracker #(
        .OFS_W      (OFS_W),
        .FIFO_DEPTH (FIFO_DEPTH)
    ) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .is_target   (is_target),
        .req_pulse   (req_pulse),
        .ack_pulse   (ack_pulse),
        .phase_chg   (phase_chg),
        .max_offset  (max_offset),
        .cnt         (offset_cnt),
        .err_ofs_ovf (e_ofs_ovf),
        .err_cap_ovf (e_cap_ovf),
        .err_ofs_unf (e_ofs_unf),
        .err_phase   (e_phase)
    );

    fifo_misuse_chk u_fifo (
        .fifo_rd    (fifo_rd),
        .fifo_wr    (fifo_wr),
        .fifo_empty (fifo_empty),
        .fifo_full  (fifo_full),
        .err_unf    (e_fifo_unf),
        .err_ovf    (e_fifo_ovf)
    );

    always_comb begin
        gross  = e_ofs_ovf | e_cap_ovf | e_ofs_unf | e_phase | e_fifo_unf | e_fifo_ovf;
        sel_ok = sel_evt & sel_en & id_match;
        rsl_ok = resel_evt & resel_en & id_match;
    end

    status_sticky u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ge  (gross),
        .set_rsl (rsl_ok),
        .set_sel (sel_ok),
        .set_cmp (arb_done),
        .rd_clr  (stat_rd_clr),
        .stat    (stat_byte)
    );

    assign irq = |stat_byte;

    AST_TARGET_ACK_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (is_target && ack_pulse && !req_pulse && offset_cnt == '0) |=> stat_byte[BIT_GE]); // R6

    AST_SEL_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_evt && sel_en && id_match) |=> stat_byte[BIT_SEL]); // R8

endmodule

// File: tb/test_sync_ofs_monitor.sv
module test_sync_ofs_monitor;

    localparam int OFS_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic is_target = 1'b1, req_pulse = 1'b0, ack_pulse = 1'b0;
    logic [OFS_W-1:0] max_offset = '0;
    logic fifo_rd = 1'b0, fifo_wr = 1'b0, fifo_empty = 1'b0, fifo_full = 1'b0;
    logic phase_chg = 1'b0, sel_evt = 1'b0, resel_evt = 1'b0, arb_done = 1'b0;
    logic sel_en = 1'b0, resel_en = 1'b0, id_match = 1'b0, stat_rd_clr = 1'b0;
    logic [7:0] stat_byte;
    logic irq;
    logic [OFS_W-1:0] offset_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sync_ofs_monitor #(.OFS_W(OFS_W), .FIFO_DEPTH(16)) i_sync_ofs_monitor (
        .clk(clk), .rst_n(rst_n), .is_target(is_target), .req_pulse(req_pulse),
        .ack_pulse(ack_pulse), .max_offset(max_offset), .fifo_rd(fifo_rd),
        .fifo_wr(fifo_wr), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
        .phase_chg(phase_chg), .sel_evt(sel_evt), .resel_evt(resel_evt),
        .arb_done(arb_done), .sel_en(sel_en), .resel_en(resel_en),
        .id_match(id_match), .stat_rd_clr(stat_rd_clr), .stat_byte(stat_byte),
        .irq(irq), .offset_cnt(offset_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Inputs are set just after a negedge; one full cycle later the result is stable.
    task automatic step();
        @(negedge clk);
        req_pulse = 0; ack_pulse = 0; fifo_rd = 0; fifo_wr = 0; fifo_empty = 0;
        fifo_full = 0; phase_chg = 0; sel_evt = 0; resel_evt = 0; arb_done = 0;
        stat_rd_clr = 0;
    endtask

    task automatic reqs(input int n);
        for (int i = 0; i < n; i++) begin req_pulse = 1; step(); end
    endtask

    task automatic clear_all();
        stat_rd_clr = 1; step();
        phase_chg = 1; step();
    endtask

    task automatic t_reset();
        chk("R13 stat", stat_byte, 0);
        chk("R13 irq", irq, 0);
        chk("R13 cnt", offset_cnt, 0);
    endtask

    task automatic t_count();
        is_target = 1; max_offset = 8;
        reqs(3);
        chk("R1 three REQ", offset_cnt, 3);
        ack_pulse = 1; step();
        chk("R1 ACK", offset_cnt, 2);
        req_pulse = 1; ack_pulse = 1; step();
        chk("R1 both", offset_cnt, 2);
        chk("R1 no error", stat_byte, 0);
        phase_chg = 1; step();
        chk("R2 phase zeroes", offset_cnt, 0);
        chk("R7 target phase no error", stat_byte, 0);
    endtask

    task automatic t_ofs_ovf();
        max_offset = 2;
        reqs(2);
        chk("R3 at max no error", stat_byte, 0);
        reqs(1);
        chk("R3 over max", stat_byte, 8'h08);
        chk("R3 count held", offset_cnt, 2);
        chk("R12 irq set", irq, 1);
        stat_rd_clr = 1; step();
        chk("R11 clear", stat_byte, 0);
        chk("R12 irq low", irq, 0);
        phase_chg = 1; step();
    endtask

    task automatic t_cap();
        max_offset = 31;
        reqs(16);
        chk("R4 sixteen ok", stat_byte, 0);
        reqs(1);
        chk("R4 capacity", stat_byte, 8'h08);
        chk("R4 count held", offset_cnt, 16);
        clear_all();
        fifo_wr = 1; step();
        chk("R4 write not full", stat_byte, 0);
        fifo_wr = 1; fifo_full = 1; step();
        chk("R4 write full", stat_byte, 8'h08);
        clear_all();
    endtask

    task automatic t_fifo_unf();
        fifo_rd = 1; step();
        chk("R5 read not empty", stat_byte, 0);
        fifo_rd = 1; fifo_empty = 1; step();
        chk("R5 read empty", stat_byte, 8'h08);
        clear_all();
    endtask

    task automatic t_ofs_unf();
        is_target = 0;
        ack_pulse = 1; step();
        chk("R6 initiator ACK at zero", stat_byte, 0);
        chk("R6 count zero", offset_cnt, 0);
        is_target = 1;
        ack_pulse = 1; step();
        chk("R6 target ACK at zero", stat_byte, 8'h08);
        chk("R6 count stays zero", offset_cnt, 0);
        clear_all();
    endtask

    task automatic t_phase_init();
        is_target = 0; max_offset = 8;
        phase_chg = 1; step();
        chk("R7 initiator phase at zero", stat_byte, 0);
        reqs(1);
        phase_chg = 1; step();
        chk("R7 initiator phase pending", stat_byte, 8'h08);
        chk("R2 phase zeroes initiator", offset_cnt, 0);
        clear_all();
        is_target = 1;
    endtask

    task automatic t_sel();
        sel_evt = 1; sel_en = 1; id_match = 0; step();
        chk("R8 no match", stat_byte, 0);
        sel_evt = 1; sel_en = 0; id_match = 1; step();
        chk("R8 not enabled", stat_byte, 0);
        sel_evt = 1; sel_en = 1; id_match = 1; step();
        chk("R8 selected", stat_byte, 8'h20);
        clear_all();
        resel_evt = 1; resel_en = 0; id_match = 1; step();
        chk("R9 not enabled", stat_byte, 0);
        resel_evt = 1; resel_en = 1; id_match = 1; step();
        chk("R9 reselected", stat_byte, 8'h10);
        clear_all();
        arb_done = 1; step();
        chk("R10 complete", stat_byte, 8'h40);
        clear_all();
        sel_en = 0; resel_en = 0; id_match = 0;
    endtask

    task automatic t_race();
        sel_evt = 1; sel_en = 1; id_match = 1; step();
        step();
        chk("R11 sticky", stat_byte, 8'h20);
        stat_rd_clr = 1; arb_done = 1; step();
        chk("R11 event wins clear", stat_byte, 8'h40);
        chk("R12 irq with cmp", irq, 1);
        clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        t_reset();
        t_count();
        t_ofs_ovf();
        t_cap();
        t_fifo_unf();
        t_ofs_unf();
        t_phase_init();
        t_sel();
        t_race();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule